// File: doc/BRIEF.md
# Host Queue and Register Bridge for AXI4-Lite

This block is an AXI4-Lite slave that connects a host processor to a DSP subsystem through a small set of queue ports and two registers. It takes the place of an older chip-select and read/write host bus. Each bus transaction is decoded into at most one single-cycle strobe toward the subsystem. The queue storage itself sits outside the block.

Each queue slot is one word address that is shared by two queues. A write to that address pushes a 16-bit word into the outbound queue toward the DSP. A read from the same address pops a word from the inbound queue toward the host. Reads from a queue slot therefore have a side effect: they consume data.

Two more addresses follow the queue slots. The first is a read-only status word. It carries status bits from the subsystem and two sticky error flags. The second is a control word that software can read and write, and its low bits act as an interrupt mask. A level-sensitive interrupt line is raised whenever an enabled status bit is set. Data travels on the low 16 bits of the 32-bit bus.

Top module: `hostq_axil_bridge`

## Requirements
- R1: A write to byte address 4*q (q < NQ) with WSTRB[1:0] = 2'b11 and tx_full[q] low raises tx_push[q] for exactly one cycle, with tx_data lane q equal to WDATA[15:0]. WDATA[31:16] is ignored and BRESP is OKAY (2'b00).
- R2: The AW and W channels may complete in either order and in different cycles. The push happens only after both have completed. Each transaction gives exactly one push, even when BREADY is held low.
- R3: A read from byte address 4*q with rx_empty[q] low raises rx_pop[q] for exactly one cycle, in the cycle the read address is accepted. RDATA equals {16'h0, rx_data lane q} and stays stable until RREADY completes the handshake. RRESP is OKAY.
- R4: A read from a queue slot whose rx_empty bit is high returns zero with OKAY and no pop. It sets the underflow sticky flag at status bit EXT_W (bit 8 by default).
- R5: A write to a queue slot whose tx_full bit is high gives no push and returns OKAY. It sets the overflow sticky flag at status bit EXT_W+1 (bit 9 by default).
- R6: The control word at byte address 4*(NQ+1) (0x00C by default) returns its last written value on read and drives ctrl_out. Each of its two bytes is written only when the matching WSTRB bit is set. It resets to zero.
- R7: The status word at byte address 4*NQ (0x008 by default) reads as {overflow, underflow, status_in}, zero-extended to 16 bits. A write to it changes nothing and returns OKAY. A read from it clears both sticky flags after returning them.
- R8: An access to any word address above NQ+1 returns SLVERR (2'b10), with RDATA zero on reads. It produces no strobe and changes no state.
- R9: irq is high exactly while (status word AND control word) is nonzero over status bits [EXT_W+1:0].
- R10: After reset, AWREADY, WREADY and ARREADY are high, BVALID and RVALID are low, and irq and ctrl_out are zero.
- R11: A queue-slot write whose WSTRB[1:0] is not 2'b11 pushes nothing and returns OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| tx_push | output | NQ | One-cycle push strobe per outbound queue |
| tx_data | output | NQ*REG_W | Push data, one lane per outbound queue |
| tx_full | input | NQ | Outbound queue full flags |
| rx_pop | output | NQ | One-cycle pop strobe per inbound queue |
| rx_data | input | NQ*REG_W | Head word of each inbound queue |
| rx_empty | input | NQ | Inbound queue empty flags |
| status_in | input | EXT_W | Status bits from the subsystem |
| ctrl_out | output | REG_W | Current control word |
| irq | output | 1 | Level interrupt |

## Verification
A write-channel hold flag that never clears would leave AWREADY or WREADY low. The next write would then hang, and the run would end on the timeout. A strobe that is duplicated or missing changes the push or pop count of the bench queue models within the same transaction. Any effect on data ordering shows up in the next RDATA from that queue. A sticky flag that is wrong shows on irq in the same cycle when its mask bit is set. Otherwise it shows on the next read of the status word.

// File: rtl/hostq_pkg.sv
package hostq_pkg;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   typedef enum logic [1:0] {
      TGT_QUEUE  = 2'd0,
      TGT_STATUS = 2'd1,
      TGT_CTRL   = 2'd2,
      TGT_NONE   = 2'd3
   } tgt_kind_e;

   typedef struct packed {
      tgt_kind_e  kind;
      logic [7:0] idx;
   } tgt_sel_t;

   // Word map: queue slots first, then status, then control.
   function automatic tgt_sel_t decode_word(input logic [31:0] word,
                                            input logic [31:0] nq);
      tgt_sel_t s;
      s.idx  = 8'd0;
      s.kind = TGT_NONE;
      if (word < nq) begin
         s.kind = TGT_QUEUE;
         s.idx  = word[7:0];
      end else if (word == nq) begin
         s.kind = TGT_STATUS;
      end else if (word == nq + 32'd1) begin
         s.kind = TGT_CTRL;
      end
      return s;
   endfunction

endpackage

// File: rtl/hostq_wr_chan.sv
module hostq_wr_chan #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   s_awaddr,
   input  logic                s_awvalid,
   output logic                s_awready,
   input  logic [DATA_W-1:0]   s_wdata,
   input  logic [DATA_W/8-1:0] s_wstrb,
   input  logic                s_wvalid,
   output logic                s_wready,
   output logic [1:0]          s_bresp,
   output logic                s_bvalid,
   input  logic                s_bready,
   output logic                commit,
   output logic [ADDR_W-1:0]   c_addr,
   output logic [DATA_W-1:0]   c_data,
   output logic [DATA_W/8-1:0] c_strb,
   input  logic                c_err
);
   import hostq_pkg::*;

   logic aw_held, w_held, bvalid_q;
   logic [1:0] bresp_q;

   assign s_awready = !aw_held && !bvalid_q;
   assign s_wready  = !w_held && !bvalid_q;
   assign commit    = aw_held && w_held && !bvalid_q;
   assign s_bvalid  = bvalid_q;
   assign s_bresp   = bresp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_held  <= 1'b0;
         w_held   <= 1'b0;
         bvalid_q <= 1'b0;
         bresp_q  <= RESP_OKAY;
         c_addr   <= '0;
         c_data   <= '0;
         c_strb   <= '0;
      end else begin
         if (s_awvalid && s_awready) begin
            aw_held <= 1'b1;
            c_addr  <= s_awaddr;
         end
         if (s_wvalid && s_wready) begin
            w_held <= 1'b1;
            c_data <= s_wdata;
            c_strb <= s_wstrb;
         end
         if (commit) begin
            aw_held  <= 1'b0;
            w_held   <= 1'b0;
            bvalid_q <= 1'b1;
            bresp_q  <= c_err ? RESP_SLVERR : RESP_OKAY;
         end else if (bvalid_q && s_bready) begin
            bvalid_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/hostq_rd_chan.sv
module hostq_rd_chan #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic              fire,
   output logic [ADDR_W-1:0] f_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_err
);
   import hostq_pkg::*;

   logic rvalid_q;

   assign s_arready = !rvalid_q;
   assign fire      = s_arvalid && s_arready;
   assign f_addr    = s_araddr;
   assign s_rvalid  = rvalid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         s_rdata  <= '0;
         s_rresp  <= RESP_OKAY;
      end else if (fire) begin
         rvalid_q <= 1'b1;
         s_rdata  <= ld_err ? '0 : ld_data;
         s_rresp  <= ld_err ? RESP_SLVERR : RESP_OKAY;
      end else if (rvalid_q && s_rready) begin
         rvalid_q <= 1'b0;
      end
   end

endmodule

// File: rtl/hostq_regs.sv
module hostq_regs #(
   parameter int REG_W = 16,
   parameter int EXT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_we,
   input  logic [REG_W-1:0]   ctrl_wdata,
   input  logic [REG_W/8-1:0] ctrl_wstrb,
   input  logic [EXT_W-1:0]   status_in,
   input  logic               set_under,
   input  logic               set_over,
   input  logic               clr_sticky,
   output logic [REG_W-1:0]   ctrl_q,
   output logic [REG_W-1:0]   status_word,
   output logic               irq
);
   localparam int STAT_W = EXT_W + 2;
   localparam int NLANE  = REG_W / 8;

   logic under_q, over_q;

   for (genvar b = 0; b < NLANE; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lane_q <= 8'h00;
         else if (ctrl_we && ctrl_wstrb[b])
            lane_q <= ctrl_wdata[b*8 +: 8];
      end
      assign ctrl_q[b*8 +: 8] = lane_q;
   end

   // A new error event wins over a clear in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         under_q <= 1'b0;
         over_q  <= 1'b0;
      end else begin
         if (set_under)       under_q <= 1'b1;
         else if (clr_sticky) under_q <= 1'b0;
         if (set_over)        over_q  <= 1'b1;
         else if (clr_sticky) over_q  <= 1'b0;
      end
   end

   if (REG_W > STAT_W) begin : g_pad
      assign status_word = {{(REG_W-STAT_W){1'b0}}, over_q, under_q, status_in};
   end else begin : g_nopad
      assign status_word = {over_q, under_q, status_in};
   end

   assign irq = |(status_word[STAT_W-1:0] & ctrl_q[STAT_W-1:0]);

endmodule

// File: rtl/hostq_axil_bridge.sv
module hostq_axil_bridge #(
   parameter int NQ     = 2,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int REG_W  = 16,
   parameter int EXT_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   s_awaddr,
   input  logic                s_awvalid,
   output logic                s_awready,
   input  logic [DATA_W-1:0]   s_wdata,
   input  logic [DATA_W/8-1:0] s_wstrb,
   input  logic                s_wvalid,
   output logic                s_wready,
   output logic [1:0]          s_bresp,
   output logic                s_bvalid,
   input  logic                s_bready,
   input  logic [ADDR_W-1:0]   s_araddr,
   input  logic                s_arvalid,
   output logic                s_arready,
   output logic [DATA_W-1:0]   s_rdata,
   output logic [1:0]          s_rresp,
   output logic                s_rvalid,
   input  logic                s_rready,
   output logic [NQ-1:0]       tx_push,
   output logic [NQ*REG_W-1:0] tx_data,
   input  logic [NQ-1:0]       tx_full,
   output logic [NQ-1:0]       rx_pop,
   input  logic [NQ*REG_W-1:0] rx_data,
   input  logic [NQ-1:0]       rx_empty,
   input  logic [EXT_W-1:0]    status_in,
   output logic [REG_W-1:0]    ctrl_out,
   output logic                irq
);
   import hostq_pkg::*;

   localparam int NLANE  = REG_W / 8;
   localparam int STAT_W = EXT_W + 2;
   localparam int WORD_W = ADDR_W - 2;

   if (NQ < 1 || NQ > 255) begin : g_bad_nq
      $error("hostq_axil_bridge: NQ must be 1..255");
   end
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data
      $error("hostq_axil_bridge: DATA_W must be 32 or 64");
   end
   if (REG_W % 8 != 0 || REG_W > DATA_W) begin : g_bad_reg
      $error("hostq_axil_bridge: REG_W must be whole bytes within DATA_W");
   end
   if (STAT_W > REG_W) begin : g_bad_ext
      $error("hostq_axil_bridge: EXT_W+2 must fit in REG_W");
   end
   if ((1 << WORD_W) < NQ + 2) begin : g_bad_addr
      $error("hostq_axil_bridge: ADDR_W too small for the word map");
   end

   // write channel
   logic                commit;
   logic [ADDR_W-1:0]   c_addr;
   logic [DATA_W-1:0]   c_data;
   logic [DATA_W/8-1:0] c_strb;
   tgt_sel_t            wsel;
   logic                w_full_lanes;
   logic [NQ-1:0]       w_hit;

   assign wsel         = decode_word(32'(c_addr[ADDR_W-1:2]), 32'(NQ));
   assign w_full_lanes = &c_strb[NLANE-1:0];

   hostq_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_awaddr  (s_awaddr),
      .s_awvalid (s_awvalid),
      .s_awready (s_awready),
      .s_wdata   (s_wdata),
      .s_wstrb   (s_wstrb),
      .s_wvalid  (s_wvalid),
      .s_wready  (s_wready),
      .s_bresp   (s_bresp),
      .s_bvalid  (s_bvalid),
      .s_bready  (s_bready),
      .commit    (commit),
      .c_addr    (c_addr),
      .c_data    (c_data),
      .c_strb    (c_strb),
      .c_err     (wsel.kind == TGT_NONE)
   );

   // read channel
   logic              fire;
   logic [ADDR_W-1:0] f_addr;
   logic [DATA_W-1:0] ld_data;
   tgt_sel_t          rsel;
   logic [NQ-1:0]     r_hit;
   logic [REG_W-1:0]  ld_word;

   assign rsel = decode_word(32'(f_addr[ADDR_W-1:2]), 32'(NQ));

   hostq_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_araddr  (s_araddr),
      .s_arvalid (s_arvalid),
      .s_arready (s_arready),
      .s_rdata   (s_rdata),
      .s_rresp   (s_rresp),
      .s_rvalid  (s_rvalid),
      .s_rready  (s_rready),
      .fire      (fire),
      .f_addr    (f_addr),
      .ld_data   (ld_data),
      .ld_err    (rsel.kind == TGT_NONE)
   );

   // per-queue strobes
   for (genvar q = 0; q < NQ; q++) begin : g_queue
      assign w_hit[q] = commit && (wsel.kind == TGT_QUEUE) && (wsel.idx == 8'(q))
                        && w_full_lanes;
      assign tx_push[q] = w_hit[q] && !tx_full[q];
      assign tx_data[q*REG_W +: REG_W] = c_data[REG_W-1:0];
      assign r_hit[q] = fire && (rsel.kind == TGT_QUEUE) && (rsel.idx == 8'(q));
      assign rx_pop[q] = r_hit[q] && !rx_empty[q];
   end

   // registers
   logic [REG_W-1:0] ctrl_q, status_word;

   hostq_regs #(.REG_W(REG_W), .EXT_W(EXT_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_we     (commit && (wsel.kind == TGT_CTRL)),
      .ctrl_wdata  (c_data[REG_W-1:0]),
      .ctrl_wstrb  (c_strb[NLANE-1:0]),
      .status_in   (status_in),
      .set_under   (|(r_hit & rx_empty)),
      .set_over    (|(w_hit & tx_full)),
      .clr_sticky  (fire && (rsel.kind == TGT_STATUS)),
      .ctrl_q      (ctrl_q),
      .status_word (status_word),
      .irq         (irq)
   );

   assign ctrl_out = ctrl_q;

   // read data select
   always_comb begin
      ld_word = '0;
      unique case (rsel.kind)
         TGT_QUEUE: begin
            for (int q = 0; q < NQ; q++)
               if (rsel.idx == 8'(q) && !rx_empty[q])
                  ld_word = rx_data[q*REG_W +: REG_W];
         end
         TGT_STATUS: ld_word = status_word;
         TGT_CTRL:   ld_word = ctrl_q;
         default:    ld_word = '0;
      endcase
   end

   if (DATA_W > REG_W) begin : g_ext
      assign ld_data = {{(DATA_W-REG_W){1'b0}}, ld_word};
   end else begin : g_noext
      assign ld_data = ld_word;
   end

   logic unused_bits;
   assign unused_bits = &{1'b0, c_addr[1:0], f_addr[1:0], c_data, c_strb};

endmodule

// File: rtl/hostq_axil_bridge_chk.sv
module hostq_axil_bridge_chk #(
   parameter int NQ    = 2,
   parameter int REG_W = 16,
   parameter int EXT_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_arvalid,
   input logic              s_arready,
   input logic [DATA_W-1:0] s_rdata,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic              s_bvalid,
   input logic              s_bready,
   input logic [NQ-1:0]     tx_push,
   input logic [NQ-1:0]     tx_full,
   input logic [NQ-1:0]     rx_pop,
   input logic [NQ-1:0]     rx_empty,
   input logic [REG_W-1:0]  ctrl_out,
   input logic              irq
);
   localparam int STAT_W = EXT_W + 2;

   assert_one_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_push));

   assert_push_then_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|tx_push) |=> s_bvalid);

   assert_no_push_while_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> (tx_push == '0));

   assert_bvalid_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> s_bvalid);

   assert_pop_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|rx_pop) |-> (s_arvalid && s_arready && $onehot(rx_pop)));

   assert_rdata_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

   assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop & rx_empty) == '0);

   assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push & tx_full) == '0);

   assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctrl_out[STAT_W-1:0] != '0));

endmodule

bind hostq_axil_bridge hostq_axil_bridge_chk #(
   .NQ(NQ), .REG_W(REG_W), .EXT_W(EXT_W), .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_arvalid (s_arvalid),
   .s_arready (s_arready),
   .s_rdata   (s_rdata),
   .s_rvalid  (s_rvalid),
   .s_rready  (s_rready),
   .s_bvalid  (s_bvalid),
   .s_bready  (s_bready),
   .tx_push   (tx_push),
   .tx_full   (tx_full),
   .rx_pop    (rx_pop),
   .rx_empty  (rx_empty),
   .ctrl_out  (ctrl_out),
   .irq       (irq)
);

// File: tb/hostq_axil_bridge_bench.sv
module hostq_axil_bridge_bench;

   localparam int RX_DEPTH = 3;
   localparam int NV = 15;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [11:0] awaddr = '0;
   logic        awvalid = 1'b0;
   logic        awready;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic        wvalid = 1'b0;
   logic        wready;
   logic [1:0]  bresp;
   logic        bvalid;
   logic        bready = 1'b0;
   logic [11:0] araddr = '0;
   logic        arvalid = 1'b0;
   logic        arready;
   logic [31:0] rdata;
   logic [1:0]  rresp;
   logic        rvalid;
   logic        rready = 1'b0;
   logic [1:0]  tx_push;
   logic [31:0] tx_data;
   logic [1:0]  tx_full = 2'b00;
   logic [1:0]  rx_pop;
   logic [31:0] rx_data;
   logic [1:0]  rx_empty;
   logic [7:0]  status_in = 8'h00;
   logic [15:0] ctrl_out;
   logic        irq;

   hostq_axil_bridge u_hostq_axil_bridge (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
      .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
      .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
      .status_in(status_in), .ctrl_out(ctrl_out), .irq(irq)
   );

   // queue models
   int          push_cnt [2] = '{0, 0};
   logic [15:0] last_tx  [2] = '{16'h0, 16'h0};
   int          rx_ptr   [2] = '{0, 0};

   always_comb begin
      for (int q = 0; q < 2; q++) begin
         rx_data[q*16 +: 16] = 16'hA000 + 16'(q * 256) + 16'(rx_ptr[q]);
         rx_empty[q]         = (rx_ptr[q] >= RX_DEPTH);
      end
   end

   always @(posedge clk) begin
      for (int q = 0; q < 2; q++) begin
         if (rst_n && tx_push[q]) begin
            push_cnt[q] <= push_cnt[q] + 1;
            last_tx[q]  <= tx_data[q*16 +: 16];
         end
         if (rst_n && rx_pop[q]) rx_ptr[q] <= rx_ptr[q] + 1;
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
      end
   endtask

   task automatic axi_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                         input int aw_lag, input int w_lag, input int b_lag,
                         output logic [1:0] resp);
      int cyc = 0;
      bit ad = 1'b0, wd = 1'b0, ha, hw;
      @(negedge clk);
      while (!(ad && wd)) begin
         if (!ad && !awvalid && cyc >= aw_lag) begin awvalid = 1'b1; awaddr = a; end
         if (!wd && !wvalid && cyc >= w_lag) begin wvalid = 1'b1; wdata = d; wstrb = s; end
         ha = awvalid && awready;
         hw = wvalid && wready;
         @(negedge clk);
         cyc++;
         if (ha) begin awvalid = 1'b0; ad = 1'b1; end
         if (hw) begin wvalid = 1'b0; wd = 1'b1; end
      end
      while (!bvalid) @(negedge clk);
      repeat (b_lag) @(negedge clk);
      resp = bresp;
      bready = 1'b1;
      @(negedge clk);
      bready = 1'b0;
   endtask

   task automatic axi_rd(input logic [11:0] a, input int r_lag,
                         output logic [1:0] resp, output logic [31:0] data, output bit held);
      bit hs;
      @(negedge clk);
      arvalid = 1'b1;
      araddr  = a;
      forever begin
         hs = arvalid && arready;
         @(negedge clk);
         if (hs) begin arvalid = 1'b0; break; end
      end
      while (!rvalid) @(negedge clk);
      data = rdata;
      held = 1'b1;
      repeat (r_lag) begin
         @(negedge clk);
         if (rdata !== data || !rvalid) held = 1'b0;
      end
      resp = rresp;
      rready = 1'b1;
      @(negedge clk);
      rready = 1'b0;
   endtask

   // {wr, addr, wdata, wstrb, resp, expected data, queue strobe mask}
   localparam logic [84:0] VEC [NV] = '{
      {1'b1, 12'h000, 32'hFFFF_1234, 4'hF, 2'b00, 32'h0000_1234, 2'b01},
      {1'b1, 12'h004, 32'h0000_BEEF, 4'h3, 2'b00, 32'h0000_BEEF, 2'b10},
      {1'b0, 12'h000, 32'h0000_0000, 4'h0, 2'b00, 32'h0000_A000, 2'b01},
      {1'b0, 12'h004, 32'h0000_0000, 4'h0, 2'b00, 32'h0000_A100, 2'b10},
      {1'b0, 12'h000, 32'h0000_0000, 4'h0, 2'b00, 32'h0000_A001, 2'b01},
      {1'b1, 12'h00C, 32'h1234_5A5A, 4'hF, 2'b00, 32'h0000_0000, 2'b00},
      {1'b0, 12'h00C, 32'h0000_0000, 4'h0, 2'b00, 32'h0000_5A5A, 2'b00},
      {1'b1, 12'h00C, 32'h0000_C300, 4'h2, 2'b00, 32'h0000_0000, 2'b00},
      {1'b0, 12'h00C, 32'h0000_0000, 4'h0, 2'b00, 32'h0000_C35A, 2'b00},
      {1'b1, 12'h010, 32'hFFFF_FFFF, 4'hF, 2'b10, 32'h0000_0000, 2'b00},
      {1'b0, 12'h3FC, 32'h0000_0000, 4'h0, 2'b10, 32'h0000_0000, 2'b00},
      {1'b1, 12'h008, 32'hFFFF_FFFF, 4'hF, 2'b00, 32'h0000_0000, 2'b00},
      {1'b0, 12'h008, 32'h0000_0000, 4'h0, 2'b00, 32'h0000_0000, 2'b00},
      {1'b1, 12'h000, 32'h0000_7777, 4'h1, 2'b00, 32'h0000_0000, 2'b00},
      {1'b1, 12'h00C, 32'h0000_0000, 4'hF, 2'b00, 32'h0000_0000, 2'b00}
   };
   string TAG [NV] = '{"R1", "R1", "R3", "R3", "R3", "R6", "R6", "R6", "R6",
                       "R8", "R8", "R7", "R7", "R11", "R6"};

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [1:0]  resp;
      logic [31:0] data;
      bit          held;
      int          p0, p1, r0, r1;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk("R10 awready", 32'(awready), 32'd1);
      chk("R10 wready", 32'(wready), 32'd1);
      chk("R10 arready", 32'(arready), 32'd1);
      chk("R10 bvalid", 32'(bvalid), 32'd0);
      chk("R10 rvalid", 32'(rvalid), 32'd0);
      chk("R10 irq", 32'(irq), 32'd0);
      chk("R10 ctrl_out", 32'(ctrl_out), 32'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [84:0] v;
         v  = VEC[i];
         p0 = push_cnt[0]; p1 = push_cnt[1];
         r0 = rx_ptr[0];   r1 = rx_ptr[1];
         if (v[84]) begin
            axi_wr(v[83:72], v[71:40], v[39:36], 0, 0, 0, resp);
            chk($sformatf("%s row %0d bresp", TAG[i], i), 32'(resp), 32'(v[35:34]));
            chk($sformatf("%s row %0d push q0", TAG[i], i), 32'(push_cnt[0] - p0), 32'(v[0]));
            chk($sformatf("%s row %0d push q1", TAG[i], i), 32'(push_cnt[1] - p1), 32'(v[1]));
            if (v[0]) chk($sformatf("%s row %0d data q0", TAG[i], i), 32'(last_tx[0]), v[33:2]);
            if (v[1]) chk($sformatf("%s row %0d data q1", TAG[i], i), 32'(last_tx[1]), v[33:2]);
         end else begin
            axi_rd(v[83:72], 0, resp, data, held);
            chk($sformatf("%s row %0d rresp", TAG[i], i), 32'(resp), 32'(v[35:34]));
            chk($sformatf("%s row %0d rdata", TAG[i], i), data, v[33:2]);
            chk($sformatf("%s row %0d pop q0", TAG[i], i), 32'(rx_ptr[0] - r0), 32'(v[0]));
            chk($sformatf("%s row %0d pop q1", TAG[i], i), 32'(rx_ptr[1] - r1), 32'(v[1]));
         end
      end

      // R3 stalled read: data held, single pop
      r0 = rx_ptr[0];
      axi_rd(12'h000, 5, resp, data, held);
      chk("R3 stalled rdata", data, 32'h0000_A002);
      chk("R3 rdata stable", 32'(held), 32'd1);
      chk("R3 single pop", 32'(rx_ptr[0] - r0), 32'd1);

      // R4 empty read
      r0 = rx_ptr[0];
      axi_rd(12'h000, 0, resp, data, held);
      chk("R4 empty rdata", data, 32'h0);
      chk("R4 empty rresp", 32'(resp), 32'd0);
      chk("R4 no pop", 32'(rx_ptr[0] - r0), 32'd0);
      axi_rd(12'h008, 0, resp, data, held);
      chk("R4 underflow flag", data, 32'h0000_0100);
      axi_rd(12'h008, 0, resp, data, held);
      chk("R7 read clears flags", data, 32'h0);

      // R5 full write
      tx_full = 2'b01;
      p0 = push_cnt[0];
      axi_wr(12'h000, 32'h0000_5555, 4'hF, 0, 0, 0, resp);
      chk("R5 full bresp", 32'(resp), 32'd0);
      chk("R5 no push", 32'(push_cnt[0] - p0), 32'd0);
      tx_full = 2'b00;
      axi_rd(12'h008, 0, resp, data, held);
      chk("R5 overflow flag", data, 32'h0000_0200);
      status_in = 8'hA5;
      axi_rd(12'h008, 0, resp, data, held);
      chk("R7 status_in readback", data, 32'h0000_00A5);
      status_in = 8'h00;

      // R2 channel ordering and stalled response
      p1 = push_cnt[1];
      axi_wr(12'h004, 32'h0000_1111, 4'hF, 0, 3, 4, resp);
      chk("R2 AW first push count", 32'(push_cnt[1] - p1), 32'd1);
      chk("R2 AW first data", 32'(last_tx[1]), 32'h1111);
      p1 = push_cnt[1];
      axi_wr(12'h004, 32'h0000_2222, 4'hF, 4, 0, 3, resp);
      chk("R2 W first push count", 32'(push_cnt[1] - p1), 32'd1);
      chk("R2 W first data", 32'(last_tx[1]), 32'h2222);
      chk("R2 bresp", 32'(resp), 32'd0);

      // R9 interrupt
      status_in = 8'h04;
      #1;
      chk("R9 masked off", 32'(irq), 32'd0);
      axi_wr(12'h00C, 32'h0000_0004, 4'hF, 0, 0, 0, resp);
      chk("R9 enabled", 32'(irq), 32'd1);
      chk("R6 ctrl_out", 32'(ctrl_out), 32'h0004);
      status_in = 8'h00;
      #1;
      chk("R9 source gone", 32'(irq), 32'd0);
      axi_wr(12'h00C, 32'h0000_0100, 4'hF, 0, 0, 0, resp);
      axi_rd(12'h000, 0, resp, data, held);
      chk("R9 sticky raises irq", 32'(irq), 32'd1);
      axi_rd(12'h008, 0, resp, data, held);
      chk("R9 clear drops irq", 32'(irq), 32'd0);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule